// File: doc/BRIEF.md
# Serial Tone Command Receiver

This block accepts tone commands from a host controller over a three-wire serial link: a data line, a serial clock and an active-low enable. Each command is five bits long and is sent least significant bit first, one bit per falling edge of the serial clock. All three link inputs are brought into the fast system clock domain through two-flop synchronizers, and the clock edges are detected there. No other clock is used.

When the fifth bit has been captured, the code is decoded into a request for a tone synthesizer. The request can be a row tone, a column tone, both, or silence. The code space holds sixteen dual-tone keypad digits, eight single-tone test codes and one stop code. The remaining seven codes are rejected: the held request does not change and an error flag pulses for one cycle. While the enable is high the block is in standby. In standby it requests no tone, ignores the link and discards any partly received command.

Row select values 0..3 stand for 697, 770, 852 and 941 Hz. Column select values 0..3 stand for 1209, 1336, 1477 and 1633 Hz.

Top module: `tone_cmd_rx`

## Requirements
- R1: A command is 5 bits, first bit = bit 0. The outputs change only when the fifth falling edge of the serial clock is processed. After four bits the held request is unchanged.
- R2: A bit is taken from the data line only at a falling edge of the serial clock. Data toggling while the serial clock is steady shifts nothing, pulses nothing and corrupts nothing.
- R3: Codes 0..15 request both tones (row_en_o=1, col_en_o=1) as {row_sel,col_sel}:
  - codes 1..9 give row=(code-1)/3, col=(code-1)%3;
  - code 10 gives {3,1}, code 11 gives {3,0} and code 12 gives {3,2};
  - codes 13, 14 and 15 give {0,3}, {1,3} and {2,3};
  - code 0 gives {3,3}.
- R4: Codes 16..23 request one tone:
  - codes 16..19 give row only, with row_sel=code-16;
  - codes 20..23 give column only, with col_sel=code-20;
  - the unused enable and its select are 0.
- R5: Code 31 clears both enables and both selects to 0.
- R6: Codes 24..30 leave all four request outputs unchanged and pulse err_o high for exactly one cycle.
- R7: While en_ni is high, both enables and both selects are 0 and no falling edge is counted. Raising en_ni discards a partly received command.
- R8: Each accepted legal code (R3, R4, R5) pulses cmd_stb_o for one cycle. cmd_stb_o and err_o are never high together.
- R9: After rst_ni is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Link enable, active low; high means standby |
| ser_clk_i | input | 1 | Serial bit clock, idle high, bit taken on its falling edge |
| ser_dat_i | input | 1 | Serial command data, LSB first |
| row_en_o | output | 1 | Row tone requested |
| row_sel_o | output | 2 | Row tone index (697/770/852/941 Hz) |
| col_en_o | output | 1 | Column tone requested |
| col_sel_o | output | 2 | Column tone index (1209/1336/1477/1633 Hz) |
| cmd_stb_o | output | 1 | One-cycle pulse when a legal command is accepted |
| err_o | output | 1 | One-cycle pulse when an unused code is rejected |

## Verification
A bit counter that is out of step shows as a wrong request or a spurious error flag on the next command. It can only be exposed by a partial command followed by a full one. A wrong decode entry shows at the request outputs about four system cycles after the fifth falling edge. A lost standby clear shows as a tone request that remains while en_ni is high. A counter that is not reset shows on the first command after enable returns. The sweep covers all 32 codes, checks held state across rejected codes, and checks partial commands in both the counting and the standby paths.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int CODE_W = 5;

  typedef struct packed {
    logic       row_en;
    logic [1:0] row_sel;
    logic       col_en;
    logic [1:0] col_sel;
  } tone_req_t;
endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
  parameter int   W      = 1,
  parameter int   STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= {W{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tone_shift.sv
module tone_shift #(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stby_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int CNT_W = $clog2(CODE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  logic              sclk_prev_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] sr_q;
  logic              fall;

  assign fall = sclk_prev_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b1;
      cnt_q       <= '0;
      sr_q        <= '0;
      done_o      <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_i;
      done_o      <= 1'b0;
      if (stby_i) begin
        cnt_q <= '0;
      end else if (fall) begin
        // LSB arrives first: shift toward bit 0
        sr_q <= {sdat_i, sr_q[CODE_W-1:1]};
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign code_o = sr_q;
endmodule

// File: rtl/tone_cmd_decode.sv
module tone_cmd_decode
  import tone_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic              legal_o,
  output tone_req_t         req_o
);
  logic [1:0] r, c;

  always_comb begin
    case (code_i[3:0])
      4'd0:  {r, c} = {2'd3, 2'd3};
      4'd1:  {r, c} = {2'd0, 2'd0};
      4'd2:  {r, c} = {2'd0, 2'd1};
      4'd3:  {r, c} = {2'd0, 2'd2};
      4'd4:  {r, c} = {2'd1, 2'd0};
      4'd5:  {r, c} = {2'd1, 2'd1};
      4'd6:  {r, c} = {2'd1, 2'd2};
      4'd7:  {r, c} = {2'd2, 2'd0};
      4'd8:  {r, c} = {2'd2, 2'd1};
      4'd9:  {r, c} = {2'd2, 2'd2};
      4'd10: {r, c} = {2'd3, 2'd1};
      4'd11: {r, c} = {2'd3, 2'd0};
      4'd12: {r, c} = {2'd3, 2'd2};
      4'd13: {r, c} = {2'd0, 2'd3};
      4'd14: {r, c} = {2'd1, 2'd3};
      default: {r, c} = {2'd2, 2'd3};
    endcase
  end

  always_comb begin
    req_o   = '0;
    legal_o = 1'b0;
    if (!code_i[4]) begin
      legal_o = 1'b1;
      req_o   = '{row_en: 1'b1, row_sel: r, col_en: 1'b1, col_sel: c};
    end else if (!code_i[3]) begin
      legal_o = 1'b1;
      if (!code_i[2]) begin
        req_o.row_en  = 1'b1;
        req_o.row_sel = code_i[1:0];
      end else begin
        req_o.col_en  = 1'b1;
        req_o.col_sel = code_i[1:0];
      end
    end else if (&code_i) begin
      legal_o = 1'b1;
    end
  end
endmodule

// File: rtl/tone_cmd_rx.sv
module tone_cmd_rx
  import tone_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_ni,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  output logic       row_en_o,
  output logic [1:0] row_sel_o,
  output logic       col_en_o,
  output logic [1:0] col_sel_o,
  output logic       cmd_stb_o,
  output logic       err_o
);
  logic [2:0]        sync_q;
  logic              stby, sclk, sdat;
  logic              done;
  logic [CODE_W-1:0] code;
  logic              legal;
  tone_req_t         req_dec, req_q;

  tone_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_ni, ser_clk_i, ser_dat_i}),
    .q_o   (sync_q)
  );
  assign {stby, sclk, sdat} = sync_q;

  tone_shift #(.CODE_W(CODE_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stby_i(stby),
    .sclk_i(sclk),
    .sdat_i(sdat),
    .done_o(done),
    .code_o(code)
  );

  tone_cmd_decode u_dec (
    .code_i (code),
    .legal_o(legal),
    .req_o  (req_dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= '0;
      cmd_stb_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      cmd_stb_o <= 1'b0;
      err_o     <= 1'b0;
      if (stby) begin
        req_q <= '0;
      end else if (done) begin
        if (legal) begin
          req_q     <= req_dec;
          cmd_stb_o <= 1'b1;
        end else begin
          err_o <= 1'b1;
        end
      end
    end
  end

  assign row_en_o  = req_q.row_en;
  assign row_sel_o = req_q.row_sel;
  assign col_en_o  = req_q.col_en;
  assign col_sel_o = req_q.col_sel;
endmodule

// File: rtl/tone_cmd_rx_chk.sv
module tone_cmd_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_ni,
  input logic       row_en_o,
  input logic [1:0] row_sel_o,
  input logic       col_en_o,
  input logic [1:0] col_sel_o,
  input logic       cmd_stb_o,
  input logic       err_o
);
  a_r6_err_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  a_r6_err_holds_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable({row_en_o, row_sel_o, col_en_o, col_sel_o}));

  a_r8_stb_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_stb_o && err_o));

  a_r8_stb_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |=> !cmd_stb_o);

  a_r7_standby_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ni && $past(en_ni) && $past(en_ni, 2) && $past(en_ni, 3))
      |-> (!row_en_o && !col_en_o && row_sel_o == 2'd0 && col_sel_o == 2'd0));

  a_r1_change_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({row_en_o, row_sel_o, col_en_o, col_sel_o})
      |-> (cmd_stb_o || {row_en_o, row_sel_o, col_en_o, col_sel_o} == 6'd0));
endmodule

bind tone_cmd_rx tone_cmd_rx_chk u_chk (.*);

// File: tb/sim_tone_cmd_rx.sv
module sim_tone_cmd_rx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_ni = 1'b1;
  logic       ser_clk = 1'b1;
  logic       ser_dat = 1'b1;
  logic       row_en, col_en, cmd_stb, err;
  logic [1:0] row_sel, col_sel;

  int checks = 0, failures = 0;
  int stb_cnt = 0, err_cnt = 0;
  bit finished = 0;
  logic [5:0] cur;

  always #2 clk = ~clk;

  tone_cmd_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_ni(en_ni),
    .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .row_en_o(row_en), .row_sel_o(row_sel),
    .col_en_o(col_en), .col_sel_o(col_sel),
    .cmd_stb_o(cmd_stb), .err_o(err)
  );

  always @(posedge clk) begin
    if (cmd_stb) stb_cnt++;
    if (err) err_cnt++;
  end

  function automatic logic [5:0] pack(bit re, int rs, bit ce, int cs);
    return {re, 2'(rs), ce, 2'(cs)};
  endfunction

  // returns {legal, row_en, row_sel, col_en, col_sel}
  function automatic logic [6:0] expect_of(int code);
    if (code == 0) return {1'b1, pack(1, 3, 1, 3)};
    if (code <= 9) return {1'b1, pack(1, (code - 1) / 3, 1, (code - 1) % 3)};
    if (code == 10) return {1'b1, pack(1, 3, 1, 1)};
    if (code == 11) return {1'b1, pack(1, 3, 1, 0)};
    if (code == 12) return {1'b1, pack(1, 3, 1, 2)};
    if (code <= 15) return {1'b1, pack(1, code - 13, 1, 3)};
    if (code <= 19) return {1'b1, pack(1, code - 16, 0, 0)};
    if (code <= 23) return {1'b1, pack(0, 0, 1, code - 20)};
    if (code == 31) return {1'b1, 6'd0};
    return 7'd0;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {row_en, row_sel, col_en, col_sel};
  endfunction

  task automatic send_bit(bit b);
    ser_dat = b;
    repeat (4) @(posedge clk);
    ser_clk = 1'b0;
    repeat (8) @(posedge clk);
    ser_clk = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic send_bits(int code, int first, int n);
    for (int i = first; i < first + n; i++) send_bit(code[i]);
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s0, e0;
    logic [6:0] ex;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {outs(), cmd_stb, err}, 8'd0);
    en_ni = 1'b0;
    repeat (6) @(posedge clk);
    cur = 6'd0;

    // R3 R4 R5 R6 R8: full sweep of the code space
    for (int code = 0; code < 32; code++) begin
      s0 = stb_cnt; e0 = err_cnt;
      send_bits(code, 0, 5);
      ex = expect_of(code);
      if (ex[6]) cur = ex[5:0];
      if (code < 16)      check("R3 dual tone", outs(), cur);
      else if (code < 24) check("R4 single tone", outs(), cur);
      else if (code == 31) check("R5 off code", outs(), cur);
      else                check("R6 unused code holds", outs(), cur);
      check("R8 strobe count", stb_cnt - s0, ex[6] ? 1 : 0);
      check("R6 error count", err_cnt - e0, ex[6] ? 0 : 1);
      if (code == 28) begin
        send_bits(6, 0, 5);
        cur = expect_of(6);
        check("R6 recovery after reject", outs(), cur);
      end
    end

    // R1: four bits give no change, fifth completes
    send_bits(5, 0, 5);
    cur = expect_of(5);
    s0 = stb_cnt;
    send_bits(14, 0, 4);
    check("R1 four bits no change", outs(), cur);
    check("R1 four bits no strobe", stb_cnt - s0, 0);
    send_bits(14, 4, 1);
    cur = expect_of(14);
    check("R1 fifth bit completes", outs(), cur);

    // R2: data toggles while serial clock is steady
    s0 = stb_cnt; e0 = err_cnt;
    for (int k = 0; k < 6; k++) begin
      ser_dat = ~ser_dat;
      repeat (5) @(posedge clk);
    end
    send_bits(20, 0, 5);
    cur = expect_of(20);
    check("R2 glitch-free decode", outs(), cur);
    check("R2 single strobe", stb_cnt - s0, 1);
    check("R2 no error", err_cnt - e0, 0);

    // R7: standby clears, ignores, discards partial
    send_bits(3, 0, 3);
    en_ni = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R7 standby clears", outs(), 6'd0);
    s0 = stb_cnt;
    send_bits(9, 0, 5);
    check("R7 link ignored in standby", {outs(), 6'(stb_cnt - s0)}, 12'd0);
    en_ni = 1'b0;
    repeat (6) @(posedge clk);
    send_bits(9, 0, 5);
    cur = expect_of(9);
    check("R7 partial discarded", outs(), cur);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule